// File: doc/BRIEF.md
# Prefix-Driven Memory Bank Extender

This block sits next to an 8-bit processor that has a 16-bit address bus. It produces the upper address bits that choose a memory bank. It holds four 8-bit bank registers. Bank 0 is the code bank and the default for every access. Banks 1 to 3 hold far-data banks. The block watches the opcode byte on the data bus at every opcode-fetch cycle, and from that byte it decides which bank the data-access cycles of the current instruction use.

A far bank can be selected in two ways. A one-byte prefix opcode arms a bank for the next instruction. Six dedicated accumulator load and store opcodes select a fixed far bank with no prefix. In both cases the far bank drives the upper address only on cycles that the processor marks as data cycles. Opcode fetches, operand fetches, stack cycles and vector cycles stay in bank 0. The processor still forms the 16-bit low address as it normally does. Software loads the bank registers through a small write port.

Top module: `bank_extender`

## Requirements
- R1: A synchronous active-low reset clears all four bank registers and any pending prefix, so `bank_hi` reads 0 after reset.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is written into the bank register given by `reg_idx` (0 is the code bank, 1 to 3 are the far banks). Later cycles use the new value.
- R3: During an opcode fetch (`op_fetch` high), and on any cycle where `data_cyc` is low, `bank_hi` equals bank register 0. A fetch strobe with `rd_wr` low (write) is not decoded as an opcode.
- R4: The prefix opcodes 0x03, 0x13 and 0x23 select far bank 1, 2 and 3. The selected bank drives `bank_hi` on the data cycles of the instruction whose opcode is fetched next. The prefix instruction itself uses bank 0.
- R5: The selection lasts through every data cycle of the modified instruction, so all three cycles of a read-modify-write use it. It ends at the next opcode fetch.
- R6: The opcodes 0xD3, 0xF3 and 0xE3 (accumulator loads) use far bank 2 on their data cycles without a prefix.
- R7: The opcodes 0x93, 0xB3 and 0xA3 (accumulator stores) use far bank 1 on their data cycles without a prefix.
- R8: When a prefix is followed directly by another prefix, only the later one takes effect.
- R9: When a prefix precedes one of the dedicated load or store opcodes, the prefix's bank takes priority over the opcode's fixed bank.
- R10: A register write that lands on a data cycle using that same register does not change `bank_hi` in that cycle. The new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_fetch | input | 1 | High in the cycle the processor fetches an opcode |
| bus_data | input | 8 | Processor data bus, carrying the opcode byte during a fetch |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| data_cyc | input | 1 | High on cycles that access instruction data |
| reg_we | input | 1 | Bank register write enable |
| reg_idx | input | 2 | Index of the bank register to write |
| reg_wdata | input | 8 | Value to write into the bank register |
| bank_hi | output | 8 | Upper address bits (the selected bank) for the current cycle |

## Verification
Two things can happen in the same cycle. A bank register write can land exactly on a data cycle whose bank comes from that same register. The bench provokes this by writing far bank 2 during the read-modify-write cycles of a prefixed instruction, and it expects the old value in that cycle and the new value on the next data cycle. Prefix decoding and a pending selection can also meet on one fetch edge: back-to-back prefixes, and a prefix placed ahead of a dedicated load opcode. The behavioural model resolves these from the requirements, and its result is compared with `bank_hi` on every clock.

// File: rtl/bank_ext_pkg.sv
// Package: shared types and opcode constants for the bank extender.
// Assumes bank register 0 is the code bank, and that registers 1 to 3 are far banks.
package bank_ext_pkg;
    localparam int NUM_BANKS = 4;
    localparam int SEL_W     = $clog2(NUM_BANKS);

    typedef logic [SEL_W-1:0] bank_sel_t;

    localparam bank_sel_t SEL_CODE = 2'd0;
    localparam bank_sel_t SEL_F1   = 2'd1;
    localparam bank_sel_t SEL_F2   = 2'd2;
    localparam bank_sel_t SEL_F3   = 2'd3;

    // Prefix opcodes, which the processor runs as single-cycle no-ops.
    localparam logic [7:0] OP_PFX1 = 8'h03;
    localparam logic [7:0] OP_PFX2 = 8'h13;
    localparam logic [7:0] OP_PFX3 = 8'h23;

    // Returns the far bank a prefix opcode selects, or SEL_CODE if the byte is not a prefix.
    function automatic bank_sel_t prefix_sel(input logic [7:0] op);
        case (op)
            OP_PFX1: prefix_sel = SEL_F1;
            OP_PFX2: prefix_sel = SEL_F2;
            OP_PFX3: prefix_sel = SEL_F3;
            default: prefix_sel = SEL_CODE;
        endcase
    endfunction

    // Returns the fixed bank of a dedicated load or store opcode, or SEL_CODE for any other byte.
    function automatic bank_sel_t implicit_sel(input logic [7:0] op);
        case (op)
            8'hD3, 8'hF3, 8'hE3: implicit_sel = SEL_F2;
            8'h93, 8'hB3, 8'hA3: implicit_sel = SEL_F1;
            default:             implicit_sel = SEL_CODE;
        endcase
    endfunction
endpackage

// File: rtl/bank_regfile.sv
// Bank register file: holds NUM_BANKS registers of BANK_W bits each, behind one write port.
// Assumes a synchronous active-low reset. A write becomes visible on the cycle after it.
module bank_regfile
    import bank_ext_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  bank_sel_t                       idx,
    input  logic [BANK_W-1:0]               wdata,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] regs
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_reg
        // Reset or load register g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && idx == bank_sel_t'(g))
                regs[g] <= wdata;
        end
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(idx)] == $past(wdata));
    a_r1_regs_cleared: assert property (@(posedge clk)
        !rst_n |=> regs[0] == '0 && regs[3] == '0);
endmodule

// File: rtl/prefix_decode.sv
// Prefix decoder: reads opcode bytes at each fetch and keeps the far-bank selection for the current instruction.
// Assumes the fetch input is already qualified with a read. A prefix arms a bank, which the next fetch takes over.
module prefix_decode
    import bank_ext_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch,
    input  logic [7:0] opcode,
    output bank_sel_t  act_sel
);
    bank_sel_t pend_sel;
    bank_sel_t pfx;
    bank_sel_t imp;

    // Classify the opcode byte on the bus.
    always_comb begin
        pfx = prefix_sel(opcode);
        imp = implicit_sel(opcode);
    end

    // Update the pending and active selections at each opcode fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel <= SEL_CODE;
            act_sel  <= SEL_CODE;
        end else if (fetch) begin
            if (pfx != SEL_CODE) begin
                pend_sel <= pfx;
                act_sel  <= SEL_CODE;
            end else begin
                pend_sel <= SEL_CODE;
                act_sel  <= (pend_sel != SEL_CODE) ? pend_sel : imp;
            end
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> pend_sel == SEL_CODE && act_sel == SEL_CODE);
    a_r8_prefix_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && opcode == OP_PFX3) |=> pend_sel == SEL_F3 && act_sel == SEL_CODE);
    a_r6_implicit_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && opcode == 8'hD3 && pend_sel == SEL_CODE) |=> act_sel == SEL_F2);
    a_r9_prefix_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && pfx == SEL_CODE && pend_sel != SEL_CODE) |=> act_sel == $past(pend_sel));
    a_r5_selection_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && pfx == SEL_CODE && imp == SEL_CODE && pend_sel == SEL_CODE) |=> act_sel == SEL_CODE);
    a_r5_held_between_fetches: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch |=> $stable(act_sel));
endmodule

// File: rtl/bank_extender.sv
// Bank extender top: drives the upper address bits for an 8-bit processor with a 16-bit address bus.
// Assumes op_fetch marks opcode fetches and data_cyc marks data-access cycles. All other cycles use bank 0.
module bank_extender
    import bank_ext_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_fetch,
    input  logic [7:0]        bus_data,
    input  logic              rd_wr,
    input  logic              data_cyc,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_idx,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] bank_hi
);
    logic [NUM_BANKS-1:0][BANK_W-1:0] regs;
    bank_sel_t act_sel;
    bank_sel_t out_sel;
    logic      fetch_rd;

    // Decode only fetches that read an opcode from the bus.
    assign fetch_rd = op_fetch && rd_wr;

    bank_regfile #(.BANK_W(BANK_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .regs  (regs)
    );

    prefix_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .fetch   (fetch_rd),
        .opcode  (bus_data),
        .act_sel (act_sel)
    );

    // Choose the far bank only on data cycles that are not fetches.
    always_comb begin
        out_sel = (op_fetch || !data_cyc) ? SEL_CODE : act_sel;
        bank_hi = regs[out_sel];
    end

    a_r3_code_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fetch || !data_cyc) |-> bank_hi == regs[0]);
    a_r4_far_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_fetch && data_cyc) |-> bank_hi == regs[act_sel]);
endmodule

// File: tb/bank_extender_bench.sv
module bank_extender_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_fetch = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       rd_wr = 1'b1;
    logic       data_cyc = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_idx = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] bank_hi;

    int total = 0;
    int bad = 0;
    bit reported = 1'b0;

    // Reference model state.
    int m_k[4];
    int m_pend = 0;
    int m_act = 0;

    bank_extender u_bank_extender (
        .clk(clk), .rst_n(rst_n), .op_fetch(op_fetch), .bus_data(bus_data),
        .rd_wr(rd_wr), .data_cyc(data_cyc), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .bank_hi(bank_hi)
    );

    always #2 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: expired, actual=hung expected=finished");
        report();
    end

    // One cycle: apply the inputs, compare with the model, then advance the model at the edge.
    task automatic step(input bit f, input logic [7:0] d, input bit r, input bit dc, input string tag);
        int exp;
        op_fetch = f; bus_data = d; rd_wr = r; data_cyc = dc;
        #1;
        exp = (f || !dc) ? m_k[0] : m_k[m_act];
        total++;
        if (bank_hi !== 8'(exp)) begin
            bad++;
            $display("FAIL %s: bank_hi actual=%0h expected=%0h", tag, bank_hi, exp);
        end
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_k[i]) m_k[i] = 0;
            m_pend = 0; m_act = 0;
        end else begin
            if (reg_we) m_k[reg_idx] = reg_wdata;
            if (f && r) begin
                if (d == 8'h03 || d == 8'h13 || d == 8'h23) begin
                    m_pend = (d == 8'h03) ? 1 : (d == 8'h13) ? 2 : 3;
                    m_act = 0;
                end else if (m_pend != 0) begin
                    m_act = m_pend; m_pend = 0;
                end else if (d == 8'hD3 || d == 8'hF3 || d == 8'hE3) m_act = 2;
                else if (d == 8'h93 || d == 8'hB3 || d == 8'hA3) m_act = 1;
                else m_act = 0;
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(input int idx, input int val, input string tag);
        reg_we = 1'b1; reg_idx = 2'(idx); reg_wdata = 8'(val);
        step(0, 8'h00, 1, 0, tag);
    endtask

    // Opcode fetch, two operand fetches, then n data cycles.
    task automatic instr(input logic [7:0] op, input int n, input bit r, input string tag);
        step(1, op, 1, 0, tag);
        step(0, 8'h00, 1, 0, tag);
        step(0, 8'h00, 1, 0, tag);
        for (int i = 0; i < n; i++) step(0, 8'h5A, r, 1, tag);
    endtask

    initial begin
        foreach (m_k[i]) m_k[i] = 0;
        @(negedge clk);
        step(0, 8'h00, 1, 0, "R1");
        step(0, 8'h00, 1, 1, "R1");
        rst_n = 1'b1;
        step(0, 8'h00, 1, 1, "R1");
        wr(0, 8'h11, "R2"); wr(1, 8'h22, "R2"); wr(2, 8'h33, "R2"); wr(3, 8'h44, "R2");
        instr(8'hAD, 1, 1, "R3");               // plain load, bank 0
        step(1, 8'h03, 1, 0, "R4");
        instr(8'hEE, 3, 1, "R5");               // prefixed read-modify-write
        instr(8'hAD, 1, 1, "R5");               // selection has ended
        step(1, 8'h23, 1, 0, "R4");
        instr(8'h2C, 1, 1, "R4");
        step(1, 8'h13, 1, 0, "R8");
        step(1, 8'h23, 1, 0, "R8");
        instr(8'hCD, 1, 1, "R8");
        instr(8'hD3, 1, 1, "R6"); instr(8'hF3, 1, 1, "R6"); instr(8'hE3, 1, 1, "R6");
        instr(8'h93, 1, 0, "R7"); instr(8'hB3, 1, 0, "R7"); instr(8'hA3, 1, 0, "R7");
        step(1, 8'h23, 1, 0, "R9");
        instr(8'hD3, 1, 1, "R9");
        step(1, 8'h03, 0, 0, "R3");             // write-strobed fetch is not decoded
        instr(8'hAD, 1, 1, "R3");
        step(1, 8'h13, 1, 0, "R10");
        instr(8'hEE, 1, 1, "R10");
        reg_we = 1'b1; reg_idx = 2'd2; reg_wdata = 8'h55;
        step(0, 8'h5A, 1, 1, "R10");            // old value in the write cycle
        step(0, 8'h5A, 0, 1, "R10");            // new value after it
        step(1, 8'h03, 1, 0, "R1");
        rst_n = 1'b0;
        step(0, 8'h00, 1, 0, "R1");
        rst_n = 1'b1;
        wr(1, 8'h66, "R1");
        instr(8'hAD, 1, 1, "R1");               // pending prefix cleared by reset
        report();
    end
endmodule